// File: doc/BRIEF.md
# Stacked-Size Chip-Select Address Decoder

This block turns a flat memory-mapped flash address into a device choice among four chip selects, named A1, A2, B1 and B2. No base address is programmed for any device. Each chip select carries only a size, counted in kilobytes, and the four regions are packed end to end from address zero upward in the fixed order A1, A2, B1, B2. A region therefore begins where the sum of the sizes below it ends. A size of zero means the chip select is unpopulated and its region occupies no address space, so a single populated device owns the window from address zero.

Software or a configuration master writes the four sizes through a small write port. The block keeps the running boundary sums in registers. For every valid lookup it returns, one cycle later, a one-hot chip select, the byte offset inside the selected device, and a miss flag for addresses beyond the populated window.

Top module: `csd_stack_decode`

## Requirements
- R1: After reset every size is zero, every output is low, and a lookup at any address reports a miss.
- R2: A write with `cfg_idx` 0, 1, 2 or 3 loads `cfg_size` (kilobytes) into the size of A1, A2, B1 or B2 respectively, and leaves the other three sizes unchanged.
- R3: Region k begins at the byte address equal to 1024 times the sum of the sizes with index below k, and spans 1024 times its own size in bytes.
- R4: A zero-size chip select is never selected, and at most one bit of `cs_o` is ever high.
- R5: On a hit, `off_o` equals the lookup address minus the start of the selected region.
- R6: An address at or above 1024 times the sum of all four sizes sets `miss_o`, with `cs_o` all zero and `off_o` zero.
- R7: The boundary sums do not wrap when all four sizes hold their largest value, and they never decrease from A1 to B2.
- R8: The results appear in the cycle after a lookup is presented, with `vld_o` high for exactly that cycle; while `vld_o` is low, `cs_o` and `miss_o` are low.
- R9: A lookup presented two or more cycles after a size write is decoded with the new size.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Size write strobe |
| cfg_idx | input | 2 | Chip select written: 0=A1, 1=A2, 2=B1, 3=B2 |
| cfg_size | input | SIZE_W | New size in kilobytes |
| lookup_vld_i | input | 1 | Lookup request valid |
| lookup_addr_i | input | ADDR_W | Address to decode |
| vld_o | output | 1 | Result valid |
| cs_o | output | 4 | One-hot chip select, bit 0 = A1 up to bit 3 = B2 |
| off_o | output | ADDR_W | Offset within the selected device |
| miss_o | output | 1 | Address lies outside every populated region |

## Verification
The bench builds the decoder with a 20-bit address and 8-bit size fields. The largest possible window of 4 x 255 KB then stays just below the 1 MB address space, so the last byte of B2 with every size at its maximum and the first address past it can both be reached. With these sizes the overflow corner can be tested directly rather than assumed. The small size field also keeps every boundary value easy to compute by hand, so the bench can check zero-size gaps, the single-device window and the off-by-one edges of each region.

// File: rtl/csd_pkg.sv
// Shared constants and types for the stacked chip-select decoder.
// Assumes exactly four chip selects whose stacking order is A1, A2, B1, B2.
package csd_pkg;
    localparam int NUM_CS   = 4;
    localparam int IDX_W    = 2;
    localparam int KB_SHIFT = 10;

    // Stacking order, lowest address first; the order is behaviour.
    typedef enum logic [IDX_W-1:0] {
        CS_A1 = 2'd0,
        CS_A2 = 2'd1,
        CS_B1 = 2'd2,
        CS_B2 = 2'd3
    } cs_idx_e;
endpackage

// File: rtl/csd_size_regs.sv
// Holds the four per-chip-select sizes in kilobytes.
// Assumes one write per cycle at most; synchronous active-low reset clears all.
module csd_size_regs
    import csd_pkg::*;
#(
    parameter int SIZE_W = 20
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [IDX_W-1:0]              idx,
    input  logic [SIZE_W-1:0]             wdata,
    output logic [NUM_CS-1:0][SIZE_W-1:0] size_o
);
    for (genvar g = 0; g < NUM_CS; g++) begin : g_reg
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
        // Load this chip select's size when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                size_o[g] <= '0;
            end else if (we && (idx == MY_IDX)) begin
                size_o[g] <= wdata;
            end
        end
    end
endmodule

// File: rtl/csd_bound_sum.sv
// Forms the running upper boundary of each stacked region, in kilobytes,
// and registers it. Assumes the sum width leaves room for NUM_CS maximum sizes.
module csd_bound_sum
    import csd_pkg::*;
#(
    parameter int SIZE_W = 20,
    localparam int SUM_W = SIZE_W + $clog2(NUM_CS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CS-1:0][SIZE_W-1:0] size_i,
    output logic [NUM_CS-1:0][SUM_W-1:0]  bound_o
);
    logic [NUM_CS-1:0][SUM_W-1:0] bound_d;

    // Prefix sum of the sizes in stacking order.
    always_comb begin
        logic [SUM_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            acc        = acc + SUM_W'(size_i[i]);
            bound_d[i] = acc;
        end
    end

    // Register the boundaries to keep the adder chain off the lookup path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bound_o <= '0;
        end else begin
            bound_o <= bound_d;
        end
    end
endmodule

// File: rtl/csd_range_match.sv
// Compares an address against the stacked boundaries and picks the region.
// Assumes boundaries are non-decreasing; purely combinational.
module csd_range_match
    import csd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 20,
    localparam int SUM_W = SIZE_W + $clog2(NUM_CS),
    localparam int BYTE_W = SUM_W + KB_SHIFT,
    localparam int CMP_W = (ADDR_W > BYTE_W) ? ADDR_W : BYTE_W
) (
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [NUM_CS-1:0][SUM_W-1:0]  bound_i,
    output logic [NUM_CS-1:0]             hit_o,
    output logic [ADDR_W-1:0]             off_o,
    output logic                          miss_o
);
    logic [CMP_W-1:0]             addr_x;
    logic [NUM_CS-1:0][CMP_W-1:0] end_x;
    logic [NUM_CS-1:0][CMP_W-1:0] start_x;

    // Widen the address and convert kilobyte boundaries to bytes.
    always_comb begin
        addr_x = CMP_W'(addr_i);
        for (int i = 0; i < NUM_CS; i++) begin
            end_x[i]   = CMP_W'(bound_i[i]) << KB_SHIFT;
            start_x[i] = (i == 0) ? '0 : (CMP_W'(bound_i[i-1]) << KB_SHIFT);
        end
    end

    // A region hits when the address lies in [start, end); empty ones never do.
    always_comb begin
        for (int i = 0; i < NUM_CS; i++) begin
            hit_o[i] = (addr_x >= start_x[i]) && (addr_x < end_x[i]);
        end
    end

    // Offset against the chosen region's start; zero on a miss.
    always_comb begin
        off_o = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (hit_o[i]) begin
                off_o = ADDR_W'(addr_x - start_x[i]);
            end
        end
        miss_o = (hit_o == '0);
    end
endmodule

// File: rtl/csd_stack_decode.sv
// Top of the stacked chip-select decoder: size registers, boundary sums,
// range match and a single output register stage.
// Assumes a lookup two cycles after a size write sees the new size.
module csd_stack_decode
    import csd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_idx,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic              lookup_vld_i,
    input  logic [ADDR_W-1:0] lookup_addr_i,
    output logic              vld_o,
    output logic [3:0]        cs_o,
    output logic [ADDR_W-1:0] off_o,
    output logic              miss_o
);
    localparam int SUM_W = SIZE_W + $clog2(NUM_CS);

    logic [NUM_CS-1:0][SIZE_W-1:0] size_q;
    logic [NUM_CS-1:0][SUM_W-1:0]  bound_q;
    logic [NUM_CS-1:0]             hit_c;
    logic [ADDR_W-1:0]             off_c;
    logic                          miss_c;

    csd_size_regs #(.SIZE_W(SIZE_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .idx    (cfg_idx),
        .wdata  (cfg_size),
        .size_o (size_q)
    );

    csd_bound_sum #(.SIZE_W(SIZE_W)) u_sum (
        .clk     (clk),
        .rst_n   (rst_n),
        .size_i  (size_q),
        .bound_o (bound_q)
    );

    csd_range_match #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_match (
        .addr_i  (lookup_addr_i),
        .bound_i (bound_q),
        .hit_o   (hit_c),
        .off_o   (off_c),
        .miss_o  (miss_c)
    );

    // Capture the decode result for one cycle per valid lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o  <= 1'b0;
            cs_o   <= '0;
            off_o  <= '0;
            miss_o <= 1'b0;
        end else if (lookup_vld_i) begin
            vld_o  <= 1'b1;
            cs_o   <= hit_c;
            off_o  <= off_c;
            miss_o <= miss_c;
        end else begin
            vld_o  <= 1'b0;
            cs_o   <= '0;
            off_o  <= '0;
            miss_o <= 1'b0;
        end
    end
endmodule

// File: rtl/csd_stack_decode_chk.sv
// Property checker for the stacked chip-select decoder, bound to the top.
module csd_stack_decode_chk
    import csd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 20,
    localparam int SUM_W = SIZE_W + $clog2(NUM_CS)
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         lookup_vld_i,
    input logic                         vld_o,
    input logic [3:0]                   cs_o,
    input logic [ADDR_W-1:0]            off_o,
    input logic                         miss_o,
    input logic [NUM_CS-1:0][SUM_W-1:0] bound_q
);
    assert_cs_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_o));

    assert_miss_no_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        miss_o |-> (cs_o == 4'b0 && off_o == '0));

    assert_hit_has_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && !miss_o) |-> ($countones(cs_o) == 1));

    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (vld_o == $past(lookup_vld_i)));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_o |-> (cs_o == 4'b0 && !miss_o));

    for (genvar g = 1; g < NUM_CS; g++) begin : g_mono
        assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
            bound_q[g] >= bound_q[g-1]);
    end
endmodule

bind csd_stack_decode csd_stack_decode_chk #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lookup_vld_i (lookup_vld_i),
    .vld_o        (vld_o),
    .cs_o         (cs_o),
    .off_o        (off_o),
    .miss_o       (miss_o),
    .bound_q      (bound_q)
);

// File: tb/csd_stack_decode_tb.sv
module csd_stack_decode_tb;
    localparam int ADDR_W = 20;
    localparam int SIZE_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [1:0]        cfg_idx = '0;
    logic [SIZE_W-1:0] cfg_size = '0;
    logic              lookup_vld_i = 1'b0;
    logic [ADDR_W-1:0] lookup_addr_i = '0;
    logic              vld_o;
    logic [3:0]        cs_o;
    logic [ADDR_W-1:0] off_o;
    logic              miss_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    csd_stack_decode #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_size(cfg_size), .lookup_vld_i(lookup_vld_i),
        .lookup_addr_i(lookup_addr_i), .vld_o(vld_o), .cs_o(cs_o),
        .off_o(off_o), .miss_o(miss_o)
    );

    // Sizes A1=4, A2=0, B1=16, B2=2 KB: A1 [0,4096), B1 [4096,20480), B2 [20480,22528).
    // Fields: [44:25] address, [24:21] chip select, [20:1] offset, [0] miss.
    localparam logic [44:0] VEC [0:8] = '{
        {20'd0,       4'b0001, 20'd0,     1'b0},
        {20'd4095,    4'b0001, 20'd4095,  1'b0},
        {20'd4096,    4'b0100, 20'd0,     1'b0},
        {20'd12345,   4'b0100, 20'd8249,  1'b0},
        {20'd20479,   4'b0100, 20'd16383, 1'b0},
        {20'd20480,   4'b1000, 20'd0,     1'b0},
        {20'd22527,   4'b1000, 20'd2047,  1'b0},
        {20'd22528,   4'b0000, 20'd0,     1'b1},
        {20'hFFFFF,   4'b0000, 20'd0,     1'b1}
    };

    task automatic put_size(input logic [1:0] idx, input logic [SIZE_W-1:0] sz);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_size = sz;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic look(input logic [ADDR_W-1:0] a, input logic [3:0] ecs,
                        input logic [ADDR_W-1:0] eoff, input logic emiss,
                        input string req);
        @(negedge clk);
        lookup_vld_i = 1'b1; lookup_addr_i = a;
        @(negedge clk);
        lookup_vld_i = 1'b0;
        total++;
        if (!(vld_o === 1'b1 && cs_o === ecs && off_o === eoff && miss_o === emiss)) begin
            bad++;
            $display("FAIL %s addr=%0d: vld=%b cs=%b off=%0d miss=%b expected vld=1 cs=%b off=%0d miss=%b",
                     req, a, vld_o, cs_o, off_o, miss_o, ecs, eoff, emiss);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet while in reset
        total++;
        if (vld_o !== 1'b0 || cs_o !== 4'b0 || miss_o !== 1'b0 || off_o !== '0) begin
            bad++;
            $display("FAIL R1 reset: vld=%b cs=%b off=%0d miss=%b expected all zero",
                     vld_o, cs_o, off_o, miss_o);
        end
        rst_n = 1'b1;
        // R1: with all sizes zero every lookup misses
        look(20'd0, 4'b0000, 20'd0, 1'b1, "R1");

        // R2 R3 R4 R5 R6: table walk
        put_size(2'd0, 8'd4);
        put_size(2'd1, 8'd0);
        put_size(2'd2, 8'd16);
        put_size(2'd3, 8'd2);
        settle();
        for (int i = 0; i < 9; i++) begin
            look(VEC[i][44:25], VEC[i][24:21], VEC[i][20:1], VEC[i][0], "R3/R5/R6 table");
        end

        // R8: idle cycle after a lookup carries no result
        @(negedge clk);
        total++;
        if (vld_o !== 1'b0 || cs_o !== 4'b0 || miss_o !== 1'b0) begin
            bad++;
            $display("FAIL R8 idle: vld=%b cs=%b miss=%b expected 0 0000 0", vld_o, cs_o, miss_o);
        end

        // R4: only B1 populated (8 KB) owns the window from zero
        put_size(2'd0, 8'd0);
        put_size(2'd3, 8'd0);
        put_size(2'd2, 8'd8);
        settle();
        look(20'd0,    4'b0100, 20'd0,    1'b0, "R4 single B1");
        look(20'd8191, 4'b0100, 20'd8191, 1'b0, "R4 single B1 top");
        look(20'd8192, 4'b0000, 20'd0,    1'b1, "R6 single B1 end");

        // R9: new A2 size is seen two cycles after the write
        put_size(2'd1, 8'd1);
        settle();
        look(20'd0,    4'b0010, 20'd0,    1'b0, "R9 A2 now first");
        look(20'd1024, 4'b0100, 20'd0,    1'b0, "R9 B1 shifted");

        // R7: all sizes at maximum, 255 KB each = 261120 bytes
        for (int k = 0; k < 4; k++) put_size(2'(k), 8'd255);
        settle();
        look(20'd261119,  4'b0001, 20'd261119, 1'b0, "R7 A1 top");
        look(20'd261120,  4'b0010, 20'd0,      1'b0, "R7 A2 start");
        look(20'd1044479, 4'b1000, 20'd261119, 1'b0, "R7 B2 last byte");
        look(20'd1044480, 4'b0000, 20'd0,      1'b1, "R7 past window");

        // R2: rewriting A1 leaves the others untouched
        put_size(2'd0, 8'd1);
        settle();
        look(20'd1024, 4'b0010, 20'd0, 1'b0, "R2 A1 rewrite");
        look(20'd1024 + 20'd261120 * 2, 4'b1000, 20'd0, 1'b0, "R2 B2 kept");

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule